// File: doc/BRIEF.md
# Reversible Half Adder-Subtractor Logic Cell

This block is a purely combinational cell that models one three-wire reversible permutation gate. The gate keeps the count of outputs equal to the count of inputs, and every input pattern maps to its own output pattern. The gate is a parameterized primitive. Three parameters choose which wire position takes each of the three roles, so all six role assignments come from one description.

The top level wraps one instance of the gate, with its roles fixed for half add/subtract use. A 3-bit operation select steers the two data bits and a constant onto the gate wires. The same gate then produces:
- half addition and half subtraction results at once, or
- XOR with AND, or
- XOR with NAND, or
- NOT with a copy, or
- NOT with XNOR.

The wrapper flags each output bit as a meaningful result or as garbage. It forces garbage bits to zero so that a consumer never sees a spurious value.

Top module: `rhc_cell`

## Requirements
- R1: For role parameters (A,B,C), naming distinct wire positions 0..2, the gate drives out[A] = in[A]^in[B]^(in[A]&in[C])^1, out[B] = in[B]^(in[A]&in[C])^1 and out[C] = in[C]^in[A], for all six role assignments.
- R2: For every one of the six role assignments, the 8 input patterns give 8 distinct output patterns, and the inputs can be recovered from the outputs.
- R3: With op_sel = 0 (add/subtract), res_o[0] = X^Y (sum or difference), res_o[1] = ~X&Y (borrow), res_o[2] = X&Y (carry) and valid_o = 3'b111.
- R4: With op_sel = 1 (AND/XOR), res_o[0] = X^Y, res_o[2] = X&Y and valid_o = 3'b101.
- R5: With op_sel = 2 (NAND/XOR), res_o[0] = X^Y, res_o[2] = ~(X&Y) and valid_o = 3'b101.
- R6: With op_sel = 3 (NOT/copy), res_o[0] = ~X, res_o[2] = X and valid_o = 3'b101, whatever the value of Y.
- R7: With op_sel = 4 (XNOR), res_o[0] = ~X, res_o[1] = ~Y, res_o[2] = ~(X^Y) and valid_o = 3'b111.
- R8: The op_sel codes 5, 6 and 7 are unused; for these codes valid_o = 3'b000 and res_o = 3'b000.
- R9: Any res_o bit whose valid_o bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code; it sets the wire routing and the constant |
| x_in | input | 1 | First data bit (X) |
| y_in | input | 1 | Second data bit (Y) |
| res_o | output | 3 | Gate outputs; garbage positions are forced to 0 |
| valid_o | output | 3 | Per-bit flag, 1 where res_o carries a result |

## Verification
There is no register anywhere between the inputs and the outputs, so every result is due in the same cycle as its stimulus. The bench changes op_sel, x_in and y_in on a falling clock edge. It samples res_o and valid_o 2 ns after the following rising edge, so the logic has settled long before any comparison. The six standalone gate instances used for the permutation checks follow the same drive-then-sample timing.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    localparam int GATE_W = 3;

    typedef enum logic [2:0] {
        OP_ADDSUB   = 3'd0,
        OP_AND_XOR  = 3'd1,
        OP_NAND_XOR = 3'd2,
        OP_NOT_COPY = 3'd3,
        OP_XNOR     = 3'd4
    } op_e;

    // Role assignment used by the cell: A at wire 1, B at wire 2, C at wire 0
    localparam int CELL_ROLE_A = 1;
    localparam int CELL_ROLE_B = 2;
    localparam int CELL_ROLE_C = 0;

endpackage

// File: rtl/rhc_r3_gate.sv
module rhc_r3_gate #(
    parameter int ROLE_A = 0,
    parameter int ROLE_B = 1,
    parameter int ROLE_C = 2
) (
    input  logic [rhc_pkg::GATE_W-1:0] g_in,
    output logic [rhc_pkg::GATE_W-1:0] g_out
);
    logic ctl_and;

    always_comb begin
        ctl_and        = g_in[ROLE_A] & g_in[ROLE_C];
        g_out          = '0;
        g_out[ROLE_A]  = g_in[ROLE_A] ^ g_in[ROLE_B] ^ ctl_and ^ 1'b1;
        g_out[ROLE_B]  = g_in[ROLE_B] ^ ctl_and ^ 1'b1;
        g_out[ROLE_C]  = g_in[ROLE_C] ^ g_in[ROLE_A];
    end

    // Inverse mapping: recover the inputs from the outputs alone (R2)
    logic rec_a, rec_b, rec_c;
    always_comb begin
        rec_a = g_out[ROLE_A] ^ g_out[ROLE_B];
        rec_c = g_out[ROLE_C] ^ rec_a;
        rec_b = g_out[ROLE_B] ^ (rec_a & rec_c) ^ 1'b1;
        a_r2_inverse_a: assert (rec_a == g_in[ROLE_A]);
        a_r2_inverse_b: assert (rec_b == g_in[ROLE_B]);
        a_r2_inverse_c: assert (rec_c == g_in[ROLE_C]);
    end

endmodule

// File: rtl/rhc_route.sv
module rhc_route (
    input  logic [2:0]                 op_sel,
    input  logic                       x_in,
    input  logic                       y_in,
    output logic [rhc_pkg::GATE_W-1:0] gate_in,
    output logic [rhc_pkg::GATE_W-1:0] keep
);
    import rhc_pkg::*;

    op_e op;

    always_comb begin
        op = op_e'(op_sel);
        case (op)
            OP_ADDSUB: begin
                gate_in = {1'b1, y_in, x_in};
                keep    = 3'b111;
            end
            OP_AND_XOR: begin
                gate_in = {1'b1, y_in, x_in};
                keep    = 3'b101;
            end
            OP_NAND_XOR: begin
                gate_in = {1'b0, y_in, x_in};
                keep    = 3'b101;
            end
            OP_NOT_COPY: begin
                gate_in = {1'b1, 1'b1, x_in};
                keep    = 3'b101;
            end
            OP_XNOR: begin
                gate_in = {y_in, x_in, 1'b1};
                keep    = 3'b111;
            end
            default: begin
                gate_in = '0;
                keep    = '0;
            end
        endcase
    end

endmodule

// File: rtl/rhc_mask.sv
module rhc_mask (
    input  logic [rhc_pkg::GATE_W-1:0] raw,
    input  logic [rhc_pkg::GATE_W-1:0] keep,
    output logic [rhc_pkg::GATE_W-1:0] res,
    output logic [rhc_pkg::GATE_W-1:0] valid
);
    always_comb begin
        res   = raw & keep;
        valid = keep;
    end
endmodule

// File: rtl/rhc_cell.sv
module rhc_cell (
    input  logic [2:0] op_sel,
    input  logic       x_in,
    input  logic       y_in,
    output logic [2:0] res_o,
    output logic [2:0] valid_o
);
    import rhc_pkg::*;

    logic [GATE_W-1:0] gate_in;
    logic [GATE_W-1:0] gate_out;
    logic [GATE_W-1:0] keep;

    rhc_route u_route (
        .op_sel  (op_sel),
        .x_in    (x_in),
        .y_in    (y_in),
        .gate_in (gate_in),
        .keep    (keep)
    );

    rhc_r3_gate #(
        .ROLE_A (CELL_ROLE_A),
        .ROLE_B (CELL_ROLE_B),
        .ROLE_C (CELL_ROLE_C)
    ) u_gate (
        .g_in  (gate_in),
        .g_out (gate_out)
    );

    rhc_mask u_mask (
        .raw   (gate_out),
        .keep  (keep),
        .res   (res_o),
        .valid (valid_o)
    );

    always_comb begin
        // R8: unused codes flag nothing and output nothing
        if (op_sel > 3'd4) begin
            a_r8_unused_quiet: assert (valid_o == 3'b000 && res_o == 3'b000);
        end
        // R9: every garbage position reads zero
        a_r9_garbage_zero: assert ((res_o & ~valid_o) == 3'b000);
        // R3: borrow and carry are never raised together
        if (op_sel == 3'd0) begin
            a_r3_no_double_out: assert (!(res_o[1] && res_o[2]));
        end
        // R6: the copy and its complement always differ
        if (op_sel == 3'd3) begin
            a_r6_copy_differs: assert (res_o[0] != res_o[2]);
        end
    end

endmodule

// File: tb/rhc_cell_test.sv
module rhc_cell_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'd7;
    logic       x_in = 1'b0;
    logic       y_in = 1'b0;
    logic [2:0] res_o, valid_o;
    logic [2:0] gx = 3'd0;
    logic [2:0] gy [6];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rhc_cell uut (
        .op_sel  (op_sel),
        .x_in    (x_in),
        .y_in    (y_in),
        .res_o   (res_o),
        .valid_o (valid_o)
    );

    rhc_r3_gate #(.ROLE_A(0), .ROLE_B(1), .ROLE_C(2)) g0 (.g_in(gx), .g_out(gy[0]));
    rhc_r3_gate #(.ROLE_A(0), .ROLE_B(2), .ROLE_C(1)) g1 (.g_in(gx), .g_out(gy[1]));
    rhc_r3_gate #(.ROLE_A(1), .ROLE_B(0), .ROLE_C(2)) g2 (.g_in(gx), .g_out(gy[2]));
    rhc_r3_gate #(.ROLE_A(1), .ROLE_B(2), .ROLE_C(0)) g3 (.g_in(gx), .g_out(gy[3]));
    rhc_r3_gate #(.ROLE_A(2), .ROLE_B(0), .ROLE_C(1)) g4 (.g_in(gx), .g_out(gy[4]));
    rhc_r3_gate #(.ROLE_A(2), .ROLE_B(1), .ROLE_C(0)) g5 (.g_in(gx), .g_out(gy[5]));

    function automatic logic [2:0] ref_gate(int a, int b, int c, logic [2:0] v);
        logic [2:0] o;
        o    = 3'd0;
        o[c] = v[c] ^ v[a];
        o[b] = ~(v[b] ^ (v[a] & v[c]));
        o[a] = ~(v[a] ^ v[b] ^ (v[a] & v[c]));
        return o;
    endfunction

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (op=%0d x=%b y=%b gx=%b)",
                     req, act, exp, op_sel, x_in, y_in, gx);
        end
    endtask

    task automatic apply(logic [2:0] op, logic x, logic y);
        @(negedge clk);
        op_sel = op; x_in = x; y_in = y;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        // R8: code 7 held through reset yields all-zero outputs and flags
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R8", {res_o, valid_o}, 6'b000000);
        rst_n = 1'b1;
    endtask

    task automatic t_gates;
        int roles [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        logic [7:0] seen [6];
        for (int g = 0; g < 6; g++) seen[g] = 8'd0;
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            gx = 3'(p);
            @(posedge clk);
            #2;
            for (int g = 0; g < 6; g++) begin
                check("R1", {3'd0, gy[g]}, {3'd0, ref_gate(roles[g][0], roles[g][1], roles[g][2], 3'(p))});
                seen[g][gy[g]] = 1'b1;
            end
        end
        for (int g = 0; g < 6; g++) check("R2", {5'd0, seen[g] == 8'hFF}, 6'd1);
    endtask

    task automatic t_addsub;
        for (int p = 0; p < 4; p++) begin
            logic x = p[1], y = p[0];
            apply(3'd0, x, y);
            check("R3", {res_o, valid_o}, {x & y, ~x & y, x ^ y, 3'b111});
        end
    endtask

    task automatic t_and_xor;
        for (int p = 0; p < 4; p++) begin
            logic x = p[1], y = p[0];
            apply(3'd1, x, y);
            check("R4", {res_o[2], res_o[0], valid_o}, {1'b0, x & y, x ^ y, 3'b101});
            check("R9", {3'd0, res_o[1], 2'd0}, 6'd0);
        end
    endtask

    task automatic t_nand_xor;
        for (int p = 0; p < 4; p++) begin
            logic x = p[1], y = p[0];
            apply(3'd2, x, y);
            check("R5", {res_o, valid_o}, {~(x & y), 1'b0, x ^ y, 3'b101});
        end
    endtask

    task automatic t_not_copy;
        for (int p = 0; p < 4; p++) begin
            logic x = p[1], y = p[0];
            apply(3'd3, x, y);
            check("R6", {res_o, valid_o}, {x, 1'b0, ~x, 3'b101});
        end
    endtask

    task automatic t_xnor;
        for (int p = 0; p < 4; p++) begin
            logic x = p[1], y = p[0];
            apply(3'd4, x, y);
            check("R7", {res_o, valid_o}, {~(x ^ y), ~y, ~x, 3'b111});
        end
    endtask

    task automatic t_unused;
        for (int op = 5; op < 8; op++) begin
            for (int p = 0; p < 4; p++) begin
                apply(3'(op), p[1], p[0]);
                check("R8", {res_o, valid_o}, 6'b000000);
            end
        end
    endtask

    initial begin
        t_reset();
        t_gates();
        t_addsub();
        t_and_xor();
        t_nand_xor();
        t_not_copy();
        t_xnor();
        t_unused();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule